// File: doc/BRIEF.md
# Coprocessor Load/Store Instruction Interface

This block connects the auxiliary instruction port of a host processor to a streaming filter engine. The host sends instructions as a 2-bit decoded opcode with a strobe. A load instruction opens a block transfer: the interface then takes operand words from the host's memory-data channel as they arrive and passes each one on to the engine, in order and unchanged. A store instruction asks for the engine's output. If the engine has not produced it yet, the store is held and a stall flag is raised towards the host.

The engine is treated as an opaque pipeline with a fixed latency and no backpressure. Its output words go into a result FIFO inside the interface. A store drains that FIFO one word per cycle onto the host return channel, in the order the engine produced the words. Each load and each store covers exactly `BLK_LEN` words (256 by default). The host issues the stores for a block only after the loads for that block have finished. While a load or a store is in progress, the instruction port reports not-ready.

Top module: `cop_ldst_if`

## Requirements
- R1: After a synchronous active-high reset, the instruction port is ready and the stall flag is low. No word goes to the engine and no word goes to the host.
- R2: An instruction accepted with opcode 01 (ready and strobe high at the same clock edge) starts a load. Each of the next `BLK_LEN` operand words appears on the engine input one cycle after it is sampled, unchanged and in arrival order.
- R3: An accepted opcode 10 starts a store. It returns `BLK_LEN` words on the host return channel in the order the engine produced them. Each word comes one cycle after it leaves the result FIFO, and never in the cycle after a stall cycle.
- R4: Opcodes 00 and 11 are ignored. The port stays ready, no stall is raised, and nothing is forwarded or returned.
- R5: Operand words presented while no load is in progress are dropped and never reach the engine input.
- R6: The instruction port is not ready from the cycle after a load or store is accepted until that transfer has moved its `BLK_LEN` words. Instructions presented in that window are ignored. The port is ready again in the cycle after the last word of the transfer.
- R7: The stall flag is high exactly while a store is in progress and the result FIFO is empty. It stays low during a store whose results are already buffered.
- R8: Engine results that arrive before or during a store are buffered up to `FIFO_DEPTH` words. A push and a pop in the same cycle lose no word and keep the order.
- R9: Results left over after a store completes stay buffered, and the next store returns them in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_op_vld | input | 1 | Instruction strobe |
| host_op | input | 2 | Opcode: 01 load, 10 store, others ignored |
| host_op_rdy | output | 1 | Interface can accept an instruction |
| host_wdata_vld | input | 1 | Operand word valid from memory |
| host_wdata | input | DATA_W | Operand word |
| host_rdata_vld | output | 1 | Result word valid towards host |
| host_rdata | output | DATA_W | Result word |
| host_stall | output | 1 | Store pending and no result available |
| eng_in_vld | output | 1 | Operand word valid towards engine |
| eng_in_data | output | DATA_W | Operand word to engine |
| eng_out_vld | input | 1 | Engine result valid |
| eng_out_data | input | DATA_W | Engine result word |

## Verification
The engine pushing a result into the FIFO and a store popping one can happen in the same cycle, and this is where ordering and occupancy are most likely to break. The bench sets up this case by starting a store right after a back-to-back load, while the model engine's long latency means results are still arriving. The store first stalls on an empty FIFO. After that, each cycle brings one new result while the previous one is returned. A scoreboard built from the loaded words judges the outcome: every returned word must match, in order, with nothing missing and nothing extra. The stall flag must be seen high during the wait and must stay low for a store whose results were already buffered.

// File: rtl/cop_pkg.sv
package cop_pkg;

    typedef enum logic [1:0] {
        OPC_NOP   = 2'b00,
        OPC_LOAD  = 2'b01,
        OPC_STORE = 2'b10,
        OPC_RSVD  = 2'b11
    } opcode_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'b00,
        PH_LOAD  = 2'b01,
        PH_STORE = 2'b10
    } phase_e;

    typedef struct packed {
        logic   accept;
        phase_e target;
    } op_decode_t;

    function automatic phase_e phase_of(input logic [1:0] op);
        case (opcode_e'(op))
            OPC_LOAD:  return PH_LOAD;
            OPC_STORE: return PH_STORE;
            default:   return PH_IDLE;
        endcase
    endfunction

    function automatic op_decode_t decode_op(input logic vld, input logic rdy,
                                             input logic [1:0] op);
        op_decode_t d;
        d.target = phase_of(op);
        d.accept = vld && rdy && (d.target != PH_IDLE);
        return d;
    endfunction

endpackage

// File: rtl/cop_seq.sv
module cop_seq
    import cop_pkg::*;
#(
    parameter int BLK_LEN = 256
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       op_vld,
    input  logic [1:0] op,
    input  logic       wd_vld,
    input  logic       pop_fire,
    output phase_e     phase,
    output logic       op_rdy,
    output logic       ld_fire
);
    localparam int CNT_W = (BLK_LEN > 1) ? $clog2(BLK_LEN) : 1;
    localparam logic [CNT_W-1:0] LAST_BEAT = CNT_W'(BLK_LEN - 1);

    phase_e           phase_q;
    logic [CNT_W-1:0] beat_q;
    op_decode_t       dec;
    logic             beat_fire;
    logic             beat_last;

    assign op_rdy    = (phase_q == PH_IDLE);
    assign dec       = decode_op(op_vld, op_rdy, op);
    assign ld_fire   = (phase_q == PH_LOAD) && wd_vld;
    assign beat_fire = ld_fire || ((phase_q == PH_STORE) && pop_fire);
    assign beat_last = (beat_q == LAST_BEAT);
    assign phase     = phase_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            beat_q  <= '0;
        end else begin
            unique case (phase_q)
                PH_IDLE: begin
                    beat_q <= '0;
                    if (dec.accept) phase_q <= dec.target;
                end
                PH_LOAD, PH_STORE: begin
                    if (beat_fire) begin
                        if (beat_last) begin
                            phase_q <= PH_IDLE;
                            beat_q  <= '0;
                        end else begin
                            beat_q <= beat_q + 1'b1;
                        end
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/cop_fwd.sv
module cop_fwd #(
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fire,
    input  logic [DATA_W-1:0] din,
    output logic              out_vld,
    output logic [DATA_W-1:0] out_data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld  <= 1'b0;
            out_data <= '0;
        end else begin
            out_vld <= fire;
            if (fire) out_data <= din;
        end
    end
endmodule

// File: rtl/cop_rfifo.sv
module cop_rfifo #(
    parameter int DATA_W = 24,
    parameter int DEPTH  = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [DATA_W-1:0] din,
    input  logic              pop,
    output logic [DATA_W-1:0] dout,
    output logic              empty,
    output logic              full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] PTR_MAX = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [CNT_W-1:0]  occ;
    logic              do_push, do_pop;

    assign empty   = (occ == '0);
    assign full    = (occ == CNT_FULL);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            occ    <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == PTR_MAX) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == PTR_MAX) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   occ <= occ + 1'b1;
                2'b01:   occ <= occ - 1'b1;
                default: occ <= occ;
            endcase
        end
    end
endmodule

// File: rtl/cop_ret.sv
module cop_ret
    import cop_pkg::*;
#(
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  phase_e            phase,
    input  logic              fifo_empty,
    input  logic [DATA_W-1:0] fifo_dout,
    output logic              pop,
    output logic              stall,
    output logic              ret_vld,
    output logic [DATA_W-1:0] ret_data
);
    logic in_store;

    assign in_store = (phase == PH_STORE);
    assign pop      = in_store && !fifo_empty;
    assign stall    = in_store && fifo_empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            ret_vld  <= 1'b0;
            ret_data <= '0;
        end else begin
            ret_vld <= pop;
            if (pop) ret_data <= fifo_dout;
        end
    end
endmodule

// File: rtl/cop_ldst_if.sv
module cop_ldst_if
    import cop_pkg::*;
#(
    parameter int DATA_W     = 24,
    parameter int BLK_LEN    = 256,
    parameter int FIFO_DEPTH = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_op_vld,
    input  logic [1:0]        host_op,
    output logic              host_op_rdy,
    input  logic              host_wdata_vld,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_rdata_vld,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_stall,
    output logic              eng_in_vld,
    output logic [DATA_W-1:0] eng_in_data,
    input  logic              eng_out_vld,
    input  logic [DATA_W-1:0] eng_out_data
);
    phase_e            phase;
    logic              ld_fire;
    logic              res_pop;
    logic              res_empty;
    logic              res_full;
    logic [DATA_W-1:0] res_dout;

    cop_seq #(.BLK_LEN(BLK_LEN)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .op_vld   (host_op_vld),
        .op       (host_op),
        .wd_vld   (host_wdata_vld),
        .pop_fire (res_pop),
        .phase    (phase),
        .op_rdy   (host_op_rdy),
        .ld_fire  (ld_fire)
    );

    cop_fwd #(.DATA_W(DATA_W)) u_fwd (
        .clk      (clk),
        .rst      (rst),
        .fire     (ld_fire),
        .din      (host_wdata),
        .out_vld  (eng_in_vld),
        .out_data (eng_in_data)
    );

    cop_rfifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (eng_out_vld),
        .din   (eng_out_data),
        .pop   (res_pop),
        .dout  (res_dout),
        .empty (res_empty),
        .full  (res_full)
    );

    cop_ret #(.DATA_W(DATA_W)) u_ret (
        .clk        (clk),
        .rst        (rst),
        .phase      (phase),
        .fifo_empty (res_empty),
        .fifo_dout  (res_dout),
        .pop        (res_pop),
        .stall      (host_stall),
        .ret_vld    (host_rdata_vld),
        .ret_data   (host_rdata)
    );
endmodule

// File: rtl/cop_ldst_if_chk.sv
module cop_ldst_if_chk (
    input logic       clk,
    input logic       rst,
    input logic       host_op_vld,
    input logic [1:0] host_op,
    input logic       host_op_rdy,
    input logic       host_wdata_vld,
    input logic       host_rdata_vld,
    input logic       host_stall,
    input logic       eng_in_vld,
    input logic       eng_out_vld,
    input logic       fifo_full
);
    assert_reset_idle_R1: assert property (@(posedge clk)
        $past(rst) |-> (host_op_rdy && !host_stall && !eng_in_vld && !host_rdata_vld));

    assert_load_busy_R2: assert property (@(posedge clk) disable iff (rst)
        (host_op_vld && host_op_rdy && host_op == 2'b01) |=> !host_op_rdy);

    assert_return_after_pop_R3: assert property (@(posedge clk) disable iff (rst)
        host_rdata_vld |-> (!$past(host_stall) && !$past(host_op_rdy)));

    assert_ignored_op_R4: assert property (@(posedge clk) disable iff (rst)
        (host_op_vld && host_op_rdy && (host_op == 2'b00 || host_op == 2'b11)) |=> host_op_rdy);

    assert_fwd_needs_load_R5: assert property (@(posedge clk) disable iff (rst)
        eng_in_vld |-> ($past(host_wdata_vld) && !$past(host_op_rdy)));

    assert_stall_in_store_R7: assert property (@(posedge clk) disable iff (rst)
        host_stall |-> !host_op_rdy);

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
        eng_out_vld |-> !fifo_full);
endmodule

bind cop_ldst_if cop_ldst_if_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .host_op_vld    (host_op_vld),
    .host_op        (host_op),
    .host_op_rdy    (host_op_rdy),
    .host_wdata_vld (host_wdata_vld),
    .host_rdata_vld (host_rdata_vld),
    .host_stall     (host_stall),
    .eng_in_vld     (eng_in_vld),
    .eng_out_vld    (eng_out_vld),
    .fifo_full      (res_full)
);

// File: tb/cop_ldst_if_bench.sv
module cop_ldst_if_bench;
    localparam int W     = 16;
    localparam int BLK   = 8;
    localparam int DEPTH = 16;
    localparam int LAT   = 12;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         host_op_vld = 1'b0;
    logic [1:0]   host_op = 2'b00;
    logic         host_op_rdy;
    logic         host_wdata_vld = 1'b0;
    logic [W-1:0] host_wdata = '0;
    logic         host_rdata_vld;
    logic [W-1:0] host_rdata;
    logic         host_stall;
    logic         eng_in_vld;
    logic [W-1:0] eng_in_data;
    logic         eng_out_vld;
    logic [W-1:0] eng_out_data;

    int checks = 0;
    int failures = 0;
    int ret_seen = 0;
    bit done = 1'b0;

    logic [W-1:0] q_eng[$];
    logic [W-1:0] q_ret[$];

    always #5 clk = ~clk;

    cop_ldst_if #(.DATA_W(W), .BLK_LEN(BLK), .FIFO_DEPTH(DEPTH)) u_cop_ldst_if (
        .clk(clk), .rst(rst),
        .host_op_vld(host_op_vld), .host_op(host_op), .host_op_rdy(host_op_rdy),
        .host_wdata_vld(host_wdata_vld), .host_wdata(host_wdata),
        .host_rdata_vld(host_rdata_vld), .host_rdata(host_rdata),
        .host_stall(host_stall),
        .eng_in_vld(eng_in_vld), .eng_in_data(eng_in_data),
        .eng_out_vld(eng_out_vld), .eng_out_data(eng_out_data)
    );

    function automatic logic [W-1:0] eng_fn(input logic [W-1:0] x);
        return W'(x * 3 + 1);
    endfunction

    // fixed-latency engine model
    logic         pv [LAT];
    logic [W-1:0] pd [LAT];
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < LAT; i++) begin pv[i] <= 1'b0; pd[i] <= '0; end
        end else begin
            pv[0] <= eng_in_vld;
            pd[0] <= eng_fn(eng_in_data);
            for (int i = 1; i < LAT; i++) begin pv[i] <= pv[i-1]; pd[i] <= pd[i-1]; end
        end
    end
    assign eng_out_vld  = pv[LAT-1];
    assign eng_out_data = pd[LAT-1];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            if (eng_in_vld) begin
                if (q_eng.size() == 0) check(1'b0, "R5 unexpected forward", int'(eng_in_data), -1);
                else begin
                    logic [W-1:0] e;
                    e = q_eng.pop_front();
                    check(eng_in_data == e, "R2 forwarded word", int'(eng_in_data), int'(e));
                end
            end
            if (host_rdata_vld) begin
                ret_seen++;
                if (q_ret.size() == 0) check(1'b0, "R3 unexpected return", int'(host_rdata), -1);
                else begin
                    logic [W-1:0] e;
                    e = q_ret.pop_front();
                    check(host_rdata == e, "R3 R8 R9 returned word", int'(host_rdata), int'(e));
                end
            end
        end
    end

    task automatic do_op(input logic [1:0] op);
        int g = 0;
        while (!host_op_rdy && g < 1000) begin @(negedge clk); g++; end
        host_op_vld = 1'b1; host_op = op;
        @(negedge clk);
        host_op_vld = 1'b0; host_op = 2'b00;
    endtask

    task automatic load_block(input int base, input int gap);
        do_op(2'b01);
        for (int i = 0; i < BLK; i++) begin
            logic [W-1:0] w;
            w = W'(base + i * 7);
            host_wdata_vld = 1'b1; host_wdata = w;
            q_eng.push_back(w);
            q_ret.push_back(eng_fn(w));
            @(negedge clk);
            host_wdata_vld = 1'b0;
            repeat (gap) @(negedge clk);
        end
    endtask

    task automatic store_block(output int stalls);
        int n0;
        int g = 0;
        do_op(2'b10);
        n0 = ret_seen;
        stalls = 0;
        while (ret_seen < n0 + BLK && g < 2000) begin
            if (host_stall) stalls++;
            @(negedge clk);
            g++;
        end
        repeat (2) @(negedge clk);
    endtask

    initial begin
        int st;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(host_op_rdy == 1'b1, "R1 ready after reset", int'(host_op_rdy), 1);
        check(host_stall == 1'b0, "R1 stall after reset", int'(host_stall), 0);
        check(eng_in_vld == 1'b0 && host_rdata_vld == 1'b0, "R1 outputs idle",
              int'(eng_in_vld) + int'(host_rdata_vld), 0);

        // R4 ignored opcodes, R5 stray operand words
        do_op(2'b00);
        check(host_op_rdy == 1'b1 && host_stall == 1'b0, "R4 opcode 00 ignored", int'(host_op_rdy), 1);
        do_op(2'b11);
        check(host_op_rdy == 1'b1 && host_stall == 1'b0, "R4 opcode 11 ignored", int'(host_op_rdy), 1);
        for (int i = 0; i < 4; i++) begin
            host_wdata_vld = 1'b1; host_wdata = W'(16'hBEE0 + i);
            @(negedge clk);
        end
        host_wdata_vld = 1'b0;
        repeat (3) @(negedge clk);
        check(host_op_rdy == 1'b1 && ret_seen == 0, "R5 stray words dropped", ret_seen, 0);

        // R6 busy window, instruction ignored during load; results buffered (R8)
        do_op(2'b01);
        check(host_op_rdy == 1'b0, "R6 not ready during load", int'(host_op_rdy), 0);
        for (int i = 0; i < BLK; i++) begin
            logic [W-1:0] w;
            w = W'(100 + i * 5);
            host_wdata_vld = 1'b1; host_wdata = w;
            if (i == 2) begin host_op_vld = 1'b1; host_op = 2'b10; end
            q_eng.push_back(w);
            q_ret.push_back(eng_fn(w));
            @(negedge clk);
            host_wdata_vld = 1'b0; host_op_vld = 1'b0;
            if (i == BLK - 1)
                check(host_op_rdy == 1'b1, "R6 ready after last load word", int'(host_op_rdy), 1);
            @(negedge clk);
        end
        repeat (LAT + 4) @(negedge clk);
        check(host_op_rdy == 1'b1 && host_stall == 1'b0 && ret_seen == 0,
              "R6 store during load ignored", ret_seen, 0);
        store_block(st);
        check(st == 0, "R7 no stall with buffered results", st, 0);
        check(host_op_rdy == 1'b1, "R6 ready after store", int'(host_op_rdy), 1);

        // R7 R8 stall then concurrent push/pop
        load_block(500, 0);
        store_block(st);
        check(st > 0, "R7 stall seen on empty FIFO", st, 1);
        check(host_stall == 1'b0, "R7 stall low after store", int'(host_stall), 0);

        // R9 leftovers held across stores
        load_block(2000, 0);
        load_block(3000, 1);
        repeat (LAT + 4) @(negedge clk);
        store_block(st);
        check(host_op_rdy == 1'b1 && q_ret.size() == BLK, "R9 leftovers kept", q_ret.size(), BLK);
        repeat (5) @(negedge clk);
        check(q_ret.size() == BLK, "R9 no return without store", q_ret.size(), BLK);
        store_block(st);
        check(st == 0, "R9 second store unstalled", st, 0);

        check(q_eng.size() == 0, "R2 all words forwarded", q_eng.size(), 0);
        check(q_ret.size() == 0, "R3 all words returned", q_ret.size(), 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule